// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block runs one successive-approximation conversion from start to finish. Software raises a start pulse, which sets the busy/start bit. The sequencer then opens the sample switch and waits a short fixed hold delay. It resolves a 10-bit code one bit per conversion-clock period, starting with the most significant bit. A trial code drives an external DAC, and a comparator answers back. The new code is committed to the result register in the last period of a fixed 12-period frame. At that same edge the busy bit drops and a sticky interrupt flag rises.

The conversion clock is an enable pulse with two possible sources. It can come from a power-of-two prescale of the system clock, or from an RC oscillator tick that has already been brought into the system clock domain. When the RC source is chosen, one instruction-cycle wait is inserted before the first conversion period. The source and the prescale are captured when the start is accepted. The previous result stays readable for the whole frame. Clearing the busy bit during a frame abandons it.

Five named states drive all of this:

| State | Role |
|---|---|
| `ST_IDLE` | Sampling |
| `ST_HOLD` | Hold-switch settling delay |
| `ST_RCWAIT` | Instruction-cycle wait, RC source only |
| `ST_CONV` | Twelve conversion periods |
| `ST_DONE` | One-cycle commit and discharge slot |

The transitions between them are:

| Transition | From | To | Taken when |
|---|---|---|---|
| start | `ST_IDLE` | `ST_HOLD` | start pulse |
| hold_to_rc | `ST_HOLD` | `ST_RCWAIT` | hold delay over, RC source captured |
| hold_to_conv | `ST_HOLD` | `ST_CONV` | hold delay over, prescaled source captured |
| rc_to_conv | `ST_RCWAIT` | `ST_CONV` | instruction-cycle wait over |
| frame_end | `ST_CONV` | `ST_DONE` | 12th conversion tick |
| resume | `ST_DONE` | `ST_IDLE` | always, one cycle later |
| abort | `ST_HOLD`, `ST_RCWAIT` or `ST_CONV` | `ST_IDLE` | `go_clr` |

Top module: `sar_adc_seq`

## Requirements
- R1: After reset the block is sampling (`sampling`=1). `go_done`, `irq_flag`, `discharge`, `result` and `dac_code` are all 0.
- R2: A `go_set` pulse while sampling raises `go_done` and drops `sampling` at the next edge, and clears `dac_code` to 0. After HOLD_CYC cycles in prescaled mode, `dac_code` becomes 10'h200, the MSB trial.
- R3: Each conversion period ends by sampling `comp_hi`. A 1 keeps the trial bit and a 0 clears it, and the next lower bit is then set as the new trial. With `comp_hi` = (input >= `dac_code`), the committed result equals the input code.
- R4: In prescaled mode `go_done` falls exactly HOLD_CYC + 12*DIV cycles after the edge that accepted `go_set`. DIV is 2 shifted left by `psel` for `psel` 0..5, and 64 for `psel` 6 and 7.
- R5: `result` keeps its old value during the frame. At the completion edge `result` loads the new code, `go_done` goes to 0 and `irq_flag` goes to 1, all together.
- R6: `discharge` is 1 during the last conversion period and the completion cycle, with `sampling`=0. `sampling` returns to 1, with `discharge` 0, one cycle after completion.
- R7: With `src_rc`=1 captured at start, the MSB trial appears HOLD_CYC + TCY_CYC cycles after the start edge. Conversion periods then advance only on `rc_tick` pulses, and the result is still correct.
- R8: A `go_set` pulse while `go_done`=1 is ignored, so the frame length and the result are unchanged.
- R9: A `go_clr` pulse while `go_done`=1 aborts the frame. At the next edge `go_done`=0 and `sampling`=1, while `result` and `irq_flag` keep their values.
- R10: `irq_flag` stays 1 until a `flag_clr` pulse, which clears it at the next edge. A set at completion wins over a clear in the same cycle.
- R11: `src_rc` and `psel` are captured at the start edge. Changing them during a frame has no effect on its timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| go_set | input | 1 | Start pulse (sets busy/start bit) |
| go_clr | input | 1 | Clear pulse for busy bit (abort) |
| flag_clr | input | 1 | Clear pulse for interrupt flag |
| src_rc | input | 1 | Conversion clock source: 1 = RC tick, 0 = prescaled |
| psel | input | 3 | Prescale select, divide by 2<<psel (max 64) |
| rc_tick | input | 1 | One-cycle RC oscillator tick, system domain |
| comp_hi | input | 1 | Comparator: analog input at or above DAC level |
| dac_code | output | 10 | Current trial code to the DAC |
| result | output | 10 | Committed conversion result |
| go_done | output | 1 | Busy/start bit, clears at completion |
| irq_flag | output | 1 | Sticky conversion-complete flag |
| sampling | output | 1 | Sample switch closed |
| discharge | output | 1 | Hold capacitor discharge |

## Verification
The assertions take for granted that the control pulses `go_set`, `go_clr` and `flag_clr` are synchronous, single-cycle and free of X after reset. They also assume `comp_hi` is a settled function of the present `dac_code`. The stimulus keeps to this by driving every input on the falling clock edge and modelling the comparator as a pure comparison of a held input code against `dac_code`. `go_clr` is only pulsed while a frame is running, and `rc_tick` comes from a fixed system-domain divider.

// File: rtl/sar_pkg.sv
package sar_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_HOLD   = 3'd1,
        ST_RCWAIT = 3'd2,
        ST_CONV   = 3'd3,
        ST_DONE   = 3'd4
    } sar_state_e;

endpackage

// File: rtl/sar_tad_gen.sv
module sar_tad_gen #(
    parameter int PSEL_W   = 3,
    parameter int MAX_LOG2 = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              use_rc,
    input  logic [PSEL_W-1:0] psel,
    input  logic              rc_tick,
    output logic              tick
);
    localparam int CNT_W = MAX_LOG2;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] lim;
    logic             hit;

    // Terminal count for the selected power-of-two divide, clamped at 2**MAX_LOG2.
    always_comb begin
        int unsigned eff;
        if (int'(psel) >= MAX_LOG2 - 1) begin
            eff = MAX_LOG2 - 1;
        end else begin
            eff = int'(psel);
        end
        lim = CNT_W'((32'd2 << eff) - 32'd1);
    end

    assign hit = (cnt_q == lim);

    // Counter restarts at zero whenever the sequencer leaves the conversion phase,
    // so the first period is always a full one.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || use_rc || hit) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    assign tick = run && (use_rc ? rc_tick : hit);

endmodule

// File: rtl/sar_approx.sv
module sar_approx #(
    parameter int RES_BITS = 10,
    localparam int IDX_W   = $clog2(RES_BITS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr,
    input  logic                load_msb,
    input  logic                resolve,
    input  logic [IDX_W-1:0]    bit_idx,
    input  logic                comp_hi,
    output logic [RES_BITS-1:0] code
);

    // One flop per code bit; each decides its own next value.
    for (genvar i = 0; i < RES_BITS; i++) begin : g_bit
        logic is_trial;
        logic is_next;
        assign is_trial = (int'(bit_idx) == i);
        assign is_next  = (int'(bit_idx) == i + 1);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                code[i] <= 1'b0;
            end else if (clr) begin
                code[i] <= 1'b0;
            end else if (load_msb) begin
                code[i] <= (i == RES_BITS - 1);
            end else if (resolve) begin
                if (is_trial) begin
                    code[i] <= comp_hi;
                end else if (is_next) begin
                    code[i] <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/sar_seq_fsm.sv
module sar_seq_fsm
    import sar_pkg::*;
#(
    parameter int RES_BITS   = 10,
    parameter int FRAME_TADS = 12,
    parameter int HOLD_CYC   = 2,
    parameter int TCY_CYC    = 4,
    parameter int PSEL_W     = 3,
    localparam int IDX_W     = $clog2(RES_BITS),
    localparam int TAD_W     = $clog2(FRAME_TADS),
    localparam int WAIT_MAX  = (HOLD_CYC > TCY_CYC) ? HOLD_CYC : TCY_CYC,
    localparam int WAIT_W    = $clog2(WAIT_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go_set,
    input  logic              go_clr,
    input  logic              src_rc,
    input  logic [PSEL_W-1:0] psel,
    input  logic              tick,
    output logic              conv_run,
    output logic              cap_rc,
    output logic [PSEL_W-1:0] cap_psel,
    output logic              sar_clr,
    output logic              sar_load,
    output logic              sar_resolve,
    output logic [IDX_W-1:0]  bit_idx,
    output logic              commit,
    output logic              busy,
    output logic              sample_on,
    output logic              dis_on
);

    sar_state_e       state_q, state_d;
    logic [WAIT_W-1:0] wcnt_q;
    logic [TAD_W-1:0]  tad_q;
    logic              wait_hold_end;
    logic              wait_rc_end;
    logic              last_tad;
    logic              abort;

    assign wait_hold_end = (wcnt_q == WAIT_W'(HOLD_CYC - 1));
    assign wait_rc_end   = (wcnt_q == WAIT_W'(TCY_CYC - 1));
    assign last_tad      = (tad_q == TAD_W'(FRAME_TADS - 1));
    assign abort         = go_clr && (state_q == ST_HOLD || state_q == ST_RCWAIT
                                      || state_q == ST_CONV);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (go_set) state_d = ST_HOLD;
            end
            ST_HOLD: begin
                if (go_clr)             state_d = ST_IDLE;
                else if (wait_hold_end) state_d = cap_rc ? ST_RCWAIT : ST_CONV;
            end
            ST_RCWAIT: begin
                if (go_clr)           state_d = ST_IDLE;
                else if (wait_rc_end) state_d = ST_CONV;
            end
            ST_CONV: begin
                if (go_clr)                state_d = ST_IDLE;
                else if (tick && last_tad) state_d = ST_DONE;
            end
            ST_DONE: begin
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Phase counters and captured settings
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wcnt_q   <= '0;
            tad_q    <= '0;
            cap_rc   <= 1'b0;
            cap_psel <= '0;
        end else begin
            if (state_d != state_q) begin
                wcnt_q <= '0;
            end else if (state_q == ST_HOLD || state_q == ST_RCWAIT) begin
                wcnt_q <= wcnt_q + WAIT_W'(1);
            end

            if (state_q != ST_CONV) begin
                tad_q <= '0;
            end else if (tick) begin
                tad_q <= tad_q + TAD_W'(1);
            end

            if (state_q == ST_IDLE && go_set) begin
                cap_rc   <= src_rc;
                cap_psel <= psel;
            end
        end
    end

    // Outputs from state
    always_comb begin
        conv_run    = 1'b0;
        busy        = 1'b0;
        sample_on   = 1'b0;
        dis_on      = 1'b0;
        sar_clr     = 1'b0;
        sar_load    = 1'b0;
        sar_resolve = 1'b0;
        commit      = 1'b0;
        bit_idx     = IDX_W'(RES_BITS - 1) - IDX_W'(tad_q);
        unique case (state_q)
            ST_IDLE: begin
                sample_on = 1'b1;
                sar_clr   = go_set;
            end
            ST_HOLD: begin
                busy     = 1'b1;
                sar_load = !go_clr && wait_hold_end && !cap_rc;
            end
            ST_RCWAIT: begin
                busy     = 1'b1;
                sar_load = !go_clr && wait_rc_end;
            end
            ST_CONV: begin
                busy        = 1'b1;
                conv_run    = 1'b1;
                dis_on      = last_tad;
                sar_resolve = !abort && tick && (int'(tad_q) < RES_BITS);
                commit      = !abort && tick && last_tad;
            end
            ST_DONE: begin
                dis_on = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/sar_adc_seq.sv
module sar_adc_seq #(
    parameter int RES_BITS   = 10,
    parameter int FRAME_TADS = 12,
    parameter int HOLD_CYC   = 2,
    parameter int TCY_CYC    = 4,
    parameter int PSEL_W     = 3,
    parameter int MAX_LOG2   = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                go_set,
    input  logic                go_clr,
    input  logic                flag_clr,
    input  logic                src_rc,
    input  logic [PSEL_W-1:0]   psel,
    input  logic                rc_tick,
    input  logic                comp_hi,
    output logic [RES_BITS-1:0] dac_code,
    output logic [RES_BITS-1:0] result,
    output logic                go_done,
    output logic                irq_flag,
    output logic                sampling,
    output logic                discharge
);
    localparam int IDX_W = $clog2(RES_BITS);

    logic              conv_run;
    logic              cap_rc;
    logic [PSEL_W-1:0] cap_psel;
    logic              tick;
    logic              sar_clr;
    logic              sar_load;
    logic              sar_resolve;
    logic [IDX_W-1:0]  bit_idx;
    logic              commit;

    sar_seq_fsm #(
        .RES_BITS   (RES_BITS),
        .FRAME_TADS (FRAME_TADS),
        .HOLD_CYC   (HOLD_CYC),
        .TCY_CYC    (TCY_CYC),
        .PSEL_W     (PSEL_W)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .go_set      (go_set),
        .go_clr      (go_clr),
        .src_rc      (src_rc),
        .psel        (psel),
        .tick        (tick),
        .conv_run    (conv_run),
        .cap_rc      (cap_rc),
        .cap_psel    (cap_psel),
        .sar_clr     (sar_clr),
        .sar_load    (sar_load),
        .sar_resolve (sar_resolve),
        .bit_idx     (bit_idx),
        .commit      (commit),
        .busy        (go_done),
        .sample_on   (sampling),
        .dis_on      (discharge)
    );

    sar_tad_gen #(
        .PSEL_W   (PSEL_W),
        .MAX_LOG2 (MAX_LOG2)
    ) u_tad (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (conv_run),
        .use_rc  (cap_rc),
        .psel    (cap_psel),
        .rc_tick (rc_tick),
        .tick    (tick)
    );

    sar_approx #(
        .RES_BITS (RES_BITS)
    ) u_sar (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (sar_clr),
        .load_msb (sar_load),
        .resolve  (sar_resolve),
        .bit_idx  (bit_idx),
        .comp_hi  (comp_hi),
        .code     (dac_code)
    );

    // Result register and sticky completion flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result   <= '0;
            irq_flag <= 1'b0;
        end else begin
            if (commit) begin
                result <= dac_code;
            end
            if (commit) begin
                irq_flag <= 1'b1;
            end else if (flag_clr) begin
                irq_flag <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/sar_adc_seq_chk.sv
module sar_adc_seq_chk #(
    parameter int RES_BITS = 10
) (
    input logic                clk,
    input logic                rst_n,
    input logic                go_set,
    input logic                go_clr,
    input logic                flag_clr,
    input logic [RES_BITS-1:0] result,
    input logic                go_done,
    input logic                irq_flag,
    input logic                sampling,
    input logic                discharge
);

    // R2
    start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sampling && go_set) |=> (go_done && !sampling));

    // R5
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(go_done) |-> $stable(result));

    // R5
    done_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(go_done) && !$past(go_clr)) |-> irq_flag);

    // R6
    resume_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(go_done) && !$past(go_clr)) |=> sampling);

    // R6
    discharge_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        discharge |-> !sampling);

    // R9
    abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (go_done && go_clr && !flag_clr) |=> (!go_done && sampling && $stable(irq_flag)));

    // R10
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_flag && !flag_clr) |=> irq_flag);

endmodule

bind sar_adc_seq sar_adc_seq_chk #(.RES_BITS(RES_BITS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .go_set    (go_set),
    .go_clr    (go_clr),
    .flag_clr  (flag_clr),
    .result    (result),
    .go_done   (go_done),
    .irq_flag  (irq_flag),
    .sampling  (sampling),
    .discharge (discharge)
);

// File: tb/sar_adc_seq_tb.sv
module sar_adc_seq_tb;

    localparam int HOLD = 2;
    localparam int TCY  = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       go_set = 1'b0;
    logic       go_clr = 1'b0;
    logic       flag_clr = 1'b0;
    logic       src_rc = 1'b0;
    logic [2:0] psel = 3'd0;
    logic       rc_tick = 1'b0;
    logic       comp_hi;
    logic [9:0] dac_code;
    logic [9:0] result;
    logic       go_done;
    logic       irq_flag;
    logic       sampling;
    logic       discharge;
    logic [9:0] vin = 10'd0;

    int checks = 0;
    int fails  = 0;
    int rc_cnt = 0;

    always #2 clk = ~clk;

    // Analog model: comparator high when the input is at or above the DAC level
    assign comp_hi = (vin >= dac_code);

    // RC tick source: one pulse every 7 system cycles
    always @(negedge clk) begin
        rc_cnt  <= (rc_cnt == 6) ? 0 : rc_cnt + 1;
        rc_tick <= (rc_cnt == 6);
    end

    sar_adc_seq u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .go_set    (go_set),
        .go_clr    (go_clr),
        .flag_clr  (flag_clr),
        .src_rc    (src_rc),
        .psel      (psel),
        .rc_tick   (rc_tick),
        .comp_hi   (comp_hi),
        .dac_code  (dac_code),
        .result    (result),
        .go_done   (go_done),
        .irq_flag  (irq_flag),
        .sampling  (sampling),
        .discharge (discharge)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int ediv(input int p);
        return (p >= 5) ? 64 : (2 << p);
    endfunction

    // Runs one frame; inj/ab give the cycle to pulse go_set/go_clr (-1 = never).
    task automatic run_conv(input int inj, input int ab, input bit perturb,
                            input logic [9:0] prev, output int cyc, output int start);
        @(negedge clk);
        go_set = 1'b1;
        @(negedge clk);
        go_set = 1'b0;
        cyc = 0;
        start = -1;
        chk(dac_code == 10'd0, "R2 dac cleared", dac_code, 0);
        while (go_done && cyc < 4000) begin
            if (dac_code != 10'd0 && start < 0) start = cyc;
            if (cyc == 3) chk(result == prev, "R5 old result kept", result, prev);
            if (perturb && cyc == 1) begin
                psel   = 3'd5;
                src_rc = ~src_rc;
            end
            go_set = (cyc == inj);
            go_clr = (cyc == ab);
            @(negedge clk);
            cyc++;
        end
        go_set = 1'b0;
        go_clr = 1'b0;
    endtask

    localparam logic [12:0] VEC [8] = '{
        {3'd0, 10'h3FF}, {3'd0, 10'h000}, {3'd1, 10'h200}, {3'd2, 10'h1FF},
        {3'd3, 10'h155}, {3'd4, 10'h2AA}, {3'd5, 10'h001}, {3'd7, 10'h0C3}
    };

    initial begin
        #400000;
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks + 1, fails);
        $finish;
    end

    initial begin
        int cyc;
        int st;
        logic [9:0] prev;

        // R1 reset state
        repeat (3) @(negedge clk);
        chk(sampling && !go_done && !irq_flag && !discharge && result == 0 && dac_code == 0,
            "R1 reset state", {sampling, go_done, irq_flag, discharge}, 8);
        rst_n = 1'b1;
        @(negedge clk);
        prev = 10'd0;

        // Vector table: prescale / input pairs
        for (int i = 0; i < 8; i++) begin
            psel = VEC[i][12:10];
            vin  = VEC[i][9:0];
            run_conv(-1, -1, 1'b0, prev, cyc, st);
            chk(st == HOLD, "R2 MSB trial after hold", st, HOLD);
            chk(cyc == HOLD + 12 * ediv(int'(psel)), "R4 frame length", cyc,
                HOLD + 12 * ediv(int'(psel)));
            chk(result == vin, "R3 result code", result, vin);
            chk(irq_flag && !go_done, "R5 commit with flag", irq_flag, 1);
            chk(discharge && !sampling, "R6 discharge in done slot", discharge, 1);
            @(negedge clk);
            chk(sampling && !discharge, "R6 sampling resumes", sampling, 1);
            prev = vin;
            flag_clr = 1'b1;
            @(negedge clk);
            flag_clr = 1'b0;
        end

        // R7 RC source: extra instruction-cycle wait, ticks from rc_tick
        src_rc = 1'b1;
        psel   = 3'd0;
        vin    = 10'h2D7;
        run_conv(-1, -1, 1'b0, prev, cyc, st);
        chk(st == HOLD + TCY, "R7 RC start delay", st, HOLD + TCY);
        chk(result == vin, "R7 RC result", result, vin);
        chk(cyc >= HOLD + TCY + 12 * 7 - 7, "R7 RC paced frame", cyc, HOLD + TCY + 12 * 7);
        prev = vin;
        src_rc = 1'b0;

        // R10 flag sticky until cleared
        repeat (5) @(negedge clk);
        chk(irq_flag, "R10 flag sticky", irq_flag, 1);
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
        chk(!irq_flag, "R10 flag cleared", irq_flag, 0);

        // R8 restart attempt during a frame is ignored
        psel = 3'd0;
        vin  = 10'h0F0;
        run_conv(10, -1, 1'b0, prev, cyc, st);
        chk(cyc == HOLD + 24, "R8 go ignored while busy", cyc, HOLD + 24);
        chk(result == vin, "R8 result intact", result, vin);
        prev = vin;
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;

        // R9 abort leaves result and flag alone
        psel = 3'd5;
        vin  = 10'h3A5;
        run_conv(-1, 100, 1'b0, prev, cyc, st);
        chk(cyc == 101, "R9 abort timing", cyc, 101);
        chk(sampling && result == prev && !irq_flag, "R9 abort state", result, prev);
        @(negedge clk);

        // R11 settings captured at start
        psel   = 3'd0;
        src_rc = 1'b0;
        vin    = 10'h111;
        run_conv(-1, -1, 1'b1, prev, cyc, st);
        chk(cyc == HOLD + 24, "R11 capture psel/source", cyc, HOLD + 24);
        chk(result == vin, "R11 result", result, vin);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule